// File: doc/BRIEF.md
# Fabric Configuration Loader Sequencer

This block is the host-side engine that programs a grid of rotatable logic tiles. Each tile holds one flip-flop and three orientation bits (diagonal, horizontal and vertical flip). Every flip-flop in the grid sits on a single serial scan path, and a two-bit commit code makes every tile copy its current flip-flop value into one of its orientation latches. The loader takes three orientation planes and an optional initial-state plane, one bit per tile. It streams each plane into the scan path and issues the matching commit code. It can also read the flip-flop contents back into a register.

A programming run may begin with an array reset of a fixed number of cycles. It then loads the planes in a fixed order: diagonal, then horizontal, then vertical. The diagonal plane must go first. The move between the idle code and the diagonal code can pass briefly through the other two codes, and those passing codes must find nothing yet written that they could spoil. During a commit the loader stops the array's clock enable and holds scan mode, so the scan path does not move. Between commits it always returns to the idle code.

A readback run shifts the whole chain once and captures the scan output. While it does so, it feeds each bit back into the chain's input, so the array state is the same after the readback as before it. Start requests are accepted only while the block is idle. Completion is marked by a one-cycle done pulse.

Top module: `fabric_cfg_loader`

## Requirements
- R1: Out of reset and whenever idle: `arr_scan_en`=0, `arr_cfg`=00, `arr_rst_n`=1, `arr_clk_en`=1, `busy`=0, `done`=0.
- R2: A programming run started with `with_reset`=1 first drives `arr_rst_n` low for exactly RST_CYC cycles, with `arr_scan_en`=1, `arr_scan_in`=0 and `arr_clk_en`=1.
- R3: Each plane is shifted for TILES cycles with `arr_scan_en`=1 and `arr_clk_en`=1, starting from its most significant bit. After the shift, plane bit k sits in tile k, where tile 0 is next to the scan input and tile TILES-1 drives the scan output.
- R4: The commit codes are issued in this order, each after its own plane: diagonal 11, then horizontal 10, then vertical 01.
- R5: Each commit code is held for HOLD cycles and is followed by one cycle of 00. Throughout this time `arr_scan_en`=1 and `arr_clk_en`=0. The code never moves straight from one nonzero value to a different nonzero value.
- R6: With `with_state`=1 (sampled at start), the initial-state plane is shifted after the vertical commit and no commit code follows it. With `with_state`=0 the vertical plane stays in the flip-flops.
- R7: Every run ends with exactly one cycle of `done`=1, with `busy`=0 and `arr_scan_en`=0 in that cycle. The block then returns to idle.
- R8: A readback run shifts for TILES cycles with `arr_scan_en`=1 and `arr_scan_in` equal to `arr_scan_out`. When it ends, `rb_data` bit k holds the former state of tile k, and the array state is unchanged. `rb_data` keeps its value until the next readback.
- R9: Start requests are ignored while a run is in progress and in the done cycle. If both starts are high in the same idle cycle, programming wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_prog | input | 1 | Start a programming run (sampled when idle) |
| start_read | input | 1 | Start a readback run (sampled when idle) |
| with_reset | input | 1 | Programming run begins with an array reset phase |
| with_state | input | 1 | Programming run ends with an initial-state load |
| diag_plane | input | TILES | Diagonal-flip bits, bit k for tile k; held steady while busy |
| horz_plane | input | TILES | Horizontal-flip bits, bit k for tile k; held steady while busy |
| vert_plane | input | TILES | Vertical-flip bits, bit k for tile k; held steady while busy |
| init_plane | input | TILES | Initial flip-flop values, bit k for tile k; held steady while busy |
| arr_scan_out | input | 1 | Scan output of the tile array (last tile) |
| arr_rst_n | output | 1 | Active-low reset to the array |
| arr_scan_en | output | 1 | Scan enable to the array |
| arr_scan_in | output | 1 | Serial data into the scan path |
| arr_clk_en | output | 1 | Clock enable for the array flip-flops |
| arr_cfg | output | 2 | Commit code: 11 diagonal, 10 horizontal, 01 vertical, 00 hold |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rb_data | output | TILES | Last readback result, bit k is tile k |

## Verification
Some properties are checked on every cycle. A nonzero commit code always comes with scan mode on and the array clock stopped. The code never jumps between two different nonzero values. The three codes appear in diagonal, horizontal, vertical order. The array reset lasts exactly RST_CYC cycles with the scan input at zero. The done pulse is a single cycle, and nothing toggles while the block is idle.

Other behaviour can only be shown by the bench scenarios, which run a behavioural tile array. These include the bit ordering that puts plane bit k into tile k, the contents of each orientation latch after a run, and the readback result. They also cover the non-destructive nature of readback and the rejection of starts during a run.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_SHIFT,
    ST_COMMIT,
    ST_SETTLE,
    ST_READ,
    ST_DONE
  } fcl_state_e;

  typedef enum logic [1:0] {
    PL_DIAG,
    PL_HORZ,
    PL_VERT,
    PL_INIT
  } fcl_plane_e;

  // Commit code that copies the flip-flops into one orientation latch set.
  function automatic logic [1:0] commit_code(fcl_plane_e p);
    case (p)
      PL_DIAG: commit_code = 2'b11;
      PL_HORZ: commit_code = 2'b10;
      PL_VERT: commit_code = 2'b01;
      default: commit_code = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/fcl_ctrl.sv
module fcl_ctrl
  import fcl_pkg::*;
#(
  parameter int TILES   = 64,
  parameter int RST_CYC = 64,
  parameter int HOLD    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_prog,
  input  logic       start_read,
  input  logic       with_reset,
  input  logic       with_state,
  output fcl_state_e state,
  output fcl_plane_e plane,
  output fcl_plane_e plane_nxt,
  output logic       load_en
);

  localparam int CMAX = (TILES > RST_CYC) ? ((TILES > HOLD) ? TILES : HOLD)
                                          : ((RST_CYC > HOLD) ? RST_CYC : HOLD);
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SHIFT_LAST = CW'(TILES - 1);
  localparam logic [CW-1:0] RST_LAST   = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD - 1);

  fcl_state_e    st_q, st_d;
  fcl_plane_e    pl_q, pl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          opt_st_q, opt_st_d;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    pl_d     = pl_q;
    cnt_d    = cnt_q;
    opt_st_d = opt_st_q;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_prog) begin
          opt_st_d = with_state;
          pl_d     = PL_DIAG;
          st_d     = with_reset ? ST_RST : ST_SHIFT;
        end else if (start_read) begin
          st_d = ST_READ;
        end
      end
      ST_RST: begin
        if (cnt_q == RST_LAST) begin
          cnt_d = '0;
          st_d  = ST_SHIFT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == SHIFT_LAST) begin
          cnt_d = '0;
          st_d  = (pl_q == PL_INIT) ? ST_DONE : ST_COMMIT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_COMMIT: begin
        if (cnt_q == HOLD_LAST) begin
          cnt_d = '0;
          st_d  = ST_SETTLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (pl_q == PL_VERT) begin
          if (opt_st_q) begin
            pl_d = PL_INIT;
            st_d = ST_SHIFT;
          end else begin
            st_d = ST_DONE;
          end
        end else begin
          pl_d = fcl_plane_e'(pl_q + 2'd1);
          st_d = ST_SHIFT;
        end
      end
      ST_READ: begin
        if (cnt_q == SHIFT_LAST) begin
          cnt_d = '0;
          st_d  = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pl_q     <= PL_DIAG;
      cnt_q    <= '0;
      opt_st_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      pl_q     <= pl_d;
      cnt_q    <= cnt_d;
      opt_st_q <= opt_st_d;
    end
  end

  assign state     = st_q;
  assign plane     = pl_q;
  assign plane_nxt = pl_d;
  assign load_en   = (st_d == ST_SHIFT) && (st_q != ST_SHIFT);

endmodule

// File: rtl/fcl_shifter.sv
module fcl_shifter
  import fcl_pkg::*;
#(
  parameter int TILES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             shift_en,
  input  fcl_plane_e       sel,
  input  logic [TILES-1:0] diag_plane,
  input  logic [TILES-1:0] horz_plane,
  input  logic [TILES-1:0] vert_plane,
  input  logic [TILES-1:0] init_plane,
  output logic             bit_out
);

  logic [TILES-1:0] src;
  logic [TILES-1:0] sh_q, sh_d;

  always_comb begin
    case (sel)
      PL_DIAG: src = diag_plane;
      PL_HORZ: src = horz_plane;
      PL_VERT: src = vert_plane;
      default: src = init_plane;
    endcase
  end

  // most significant bit leaves first, so it travels to the far end of the chain
  always_comb begin
    sh_d = sh_q;
    if (load_en) begin
      sh_d = src;
    end else if (shift_en) begin
      sh_d = {sh_q[TILES-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign bit_out = sh_q[TILES-1];

endmodule

// File: rtl/fcl_capture.sv
module fcl_capture #(
  parameter int TILES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             bit_in,
  output logic [TILES-1:0] data
);

  logic [TILES-1:0] cap_q, cap_d;

  // first bit seen comes from the last tile and ends up in the top position
  always_comb begin
    cap_d = cap_q;
    if (cap_en) begin
      cap_d = {cap_q[TILES-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q <= cap_d;
    end
  end

  assign data = cap_q;

endmodule

// File: rtl/fabric_cfg_loader.sv
module fabric_cfg_loader
  import fcl_pkg::*;
#(
  parameter int TILES   = 64,
  parameter int RST_CYC = 64,
  parameter int HOLD    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_prog,
  input  logic             start_read,
  input  logic             with_reset,
  input  logic             with_state,
  input  logic [TILES-1:0] diag_plane,
  input  logic [TILES-1:0] horz_plane,
  input  logic [TILES-1:0] vert_plane,
  input  logic [TILES-1:0] init_plane,
  input  logic             arr_scan_out,
  output logic             arr_rst_n,
  output logic             arr_scan_en,
  output logic             arr_scan_in,
  output logic             arr_clk_en,
  output logic [1:0]       arr_cfg,
  output logic             busy,
  output logic             done,
  output logic [TILES-1:0] rb_data
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  fcl_state_e state;
  fcl_plane_e plane, plane_nxt;
  logic       load_en, shift_en, cap_en, sh_bit;

  fcl_ctrl #(
    .TILES  (TILES),
    .RST_CYC(RST_CYC),
    .HOLD   (HOLD)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_prog(start_prog),
    .start_read(start_read),
    .with_reset(with_reset),
    .with_state(with_state),
    .state     (state),
    .plane     (plane),
    .plane_nxt (plane_nxt),
    .load_en   (load_en)
  );

  assign shift_en = (state == ST_SHIFT);
  assign cap_en   = (state == ST_READ);

  fcl_shifter #(.TILES(TILES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .sel       (plane_nxt),
    .diag_plane(diag_plane),
    .horz_plane(horz_plane),
    .vert_plane(vert_plane),
    .init_plane(init_plane),
    .bit_out   (sh_bit)
  );

  fcl_capture #(.TILES(TILES)) u_cap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cap_en(cap_en),
    .bit_in(arr_scan_out),
    .data  (rb_data)
  );

  // array-side drive, decoded from the sequencer state
  always_comb begin
    arr_rst_n   = 1'b1;
    arr_scan_en = 1'b0;
    arr_scan_in = 1'b0;
    arr_clk_en  = 1'b1;
    arr_cfg     = 2'b00;
    busy        = 1'b1;
    done        = 1'b0;
    case (state)
      ST_IDLE: busy = 1'b0;
      ST_RST: begin
        arr_rst_n   = 1'b0;
        arr_scan_en = 1'b1;
      end
      ST_SHIFT: begin
        arr_scan_en = 1'b1;
        arr_scan_in = sh_bit;
      end
      ST_COMMIT: begin
        arr_scan_en = 1'b1;
        arr_clk_en  = 1'b0;
        arr_cfg     = commit_code(plane);
      end
      ST_SETTLE: begin
        arr_scan_en = 1'b1;
        arr_clk_en  = 1'b0;
      end
      ST_READ: begin
        arr_scan_en = 1'b1;
        arr_scan_in = arr_scan_out;
      end
      ST_DONE: begin
        busy = 1'b0;
        done = 1'b1;
      end
      default: busy = 1'b0;
    endcase
  end

endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int RST_CYC = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       arr_rst_n,
  input logic       arr_scan_en,
  input logic       arr_scan_in,
  input logic       arr_clk_en,
  input logic [1:0] arr_cfg,
  input logic       busy,
  input logic       done
);

  logic [1:0]  last_code_q;
  logic [15:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_code_q <= 2'b00;
      low_cnt_q   <= '0;
    end else begin
      if (done) begin
        last_code_q <= 2'b00;
      end else if (arr_cfg != 2'b00) begin
        last_code_q <= arr_cfg;
      end
      if (!arr_rst_n) begin
        low_cnt_q <= low_cnt_q + 16'd1;
      end else begin
        low_cnt_q <= '0;
      end
    end
  end

  // R1
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (!arr_scan_en && arr_cfg == 2'b00 && arr_rst_n && arr_clk_en));

  // R2
  p_reset_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_rst_n) |-> (low_cnt_q == 16'(RST_CYC)));

  // R2
  p_reset_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_rst_n |-> (arr_scan_en && !arr_scan_in && busy));

  // R4
  p_commit_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cfg != 2'b00 && arr_cfg != last_code_q) |->
      ((arr_cfg == 2'b11 && last_code_q == 2'b00) ||
       (arr_cfg == 2'b10 && last_code_q == 2'b11) ||
       (arr_cfg == 2'b01 && last_code_q == 2'b10)));

  // R5
  p_commit_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cfg != 2'b00) |-> (arr_scan_en && !arr_clk_en));

  // R5
  p_no_code_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cfg != 2'b00) |=> (arr_cfg == 2'b00 || arr_cfg == $past(arr_cfg)));

  // R7
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !arr_scan_en));

endmodule

bind fabric_cfg_loader fcl_checker #(.RST_CYC(RST_CYC)) u_fcl_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr_rst_n  (arr_rst_n),
  .arr_scan_en(arr_scan_en),
  .arr_scan_in(arr_scan_in),
  .arr_clk_en (arr_clk_en),
  .arr_cfg    (arr_cfg),
  .busy       (busy),
  .done       (done)
);

// File: tb/fabric_cfg_loader_bench.sv
`timescale 1ns/1ps
module fabric_cfg_loader_bench;

  localparam int TILES   = 64;
  localparam int RST_CYC = 64;
  localparam int HOLD    = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_prog, start_read, with_reset, with_state;
  logic [TILES-1:0] diag_plane, horz_plane, vert_plane, init_plane;
  logic             arr_scan_out;
  logic             arr_rst_n, arr_scan_en, arr_scan_in, arr_clk_en;
  logic [1:0]       arr_cfg;
  logic             busy, done;
  logic [TILES-1:0] rb_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit run_cmp = 1'b0;

  always #4 clk = ~clk;

  fabric_cfg_loader #(
    .TILES(TILES), .RST_CYC(RST_CYC), .HOLD(HOLD)
  ) u_fabric_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_read(start_read),
    .with_reset(with_reset), .with_state(with_state),
    .diag_plane(diag_plane), .horz_plane(horz_plane), .vert_plane(vert_plane),
    .init_plane(init_plane), .arr_scan_out(arr_scan_out),
    .arr_rst_n(arr_rst_n), .arr_scan_en(arr_scan_en), .arr_scan_in(arr_scan_in),
    .arr_clk_en(arr_clk_en), .arr_cfg(arr_cfg), .busy(busy), .done(done),
    .rb_data(rb_data)
  );

  // behavioural tile array: tile 0 next to scan input, last tile drives scan output
  logic [TILES-1:0] t_ff, t_diag, t_horz, t_vert;
  assign arr_scan_out = t_ff[TILES-1];
  always @(posedge clk) begin
    if (arr_clk_en && arr_scan_en) t_ff <= {t_ff[TILES-2:0], arr_scan_in};
    case (arr_cfg)
      2'b11: t_diag <= t_ff;
      2'b10: t_horz <= t_ff;
      2'b01: t_vert <= t_ff;
      default: ;
    endcase
  end

  // expected per-cycle outputs; si: 0/1 literal, 2 means "equal to scan output"
  typedef struct {
    bit       rstn;
    bit       se;
    bit       ce;
    bit [1:0] cfg;
    int       si;
    bit       bsy;
    bit       dn;
    int       req;
  } exp_t;
  exp_t q[$];

  task automatic push(bit rstn, bit se, bit ce, bit [1:0] cfg, int si, bit bsy, bit dn, int req);
    exp_t e;
    e.rstn = rstn; e.se = se; e.ce = ce; e.cfg = cfg; e.si = si;
    e.bsy = bsy; e.dn = dn; e.req = req;
    q.push_back(e);
  endtask

  task automatic build_prog(bit do_rst, bit do_st);
    logic [TILES-1:0] pl;
    logic [1:0] code;
    if (do_rst) for (int i = 0; i < RST_CYC; i++) push(0, 1, 1, 2'b00, 0, 1, 0, 2); // R2
    for (int p = 0; p < 3; p++) begin
      pl   = (p == 0) ? diag_plane : (p == 1) ? horz_plane : vert_plane;
      code = (p == 0) ? 2'b11 : (p == 1) ? 2'b10 : 2'b01; // R4 order
      for (int i = 0; i < TILES; i++) push(1, 1, 1, 2'b00, int'(pl[TILES-1-i]), 1, 0, 3); // R3
      for (int h = 0; h < HOLD; h++) push(1, 1, 0, code, 0, 1, 0, 4);
      push(1, 1, 0, 2'b00, 0, 1, 0, 5); // R5 settle
    end
    if (do_st) for (int i = 0; i < TILES; i++) push(1, 1, 1, 2'b00, int'(init_plane[TILES-1-i]), 1, 0, 6); // R6
    push(1, 0, 1, 2'b00, 0, 0, 1, 7); // R7
  endtask

  task automatic build_read();
    for (int i = 0; i < TILES; i++) push(1, 1, 1, 2'b00, 2, 1, 0, 8); // R8
    push(1, 0, 1, 2'b00, 0, 0, 1, 7);
  endtask

  // reference model advance: start only taken when no run is pending (R9)
  always @(posedge clk) begin
    if (run_cmp) begin
      if (q.size() != 0) void'(q.pop_front());
      else if (start_prog) build_prog(with_reset, with_state);
      else if (start_read) build_read();
    end
  end

  always @(negedge clk) begin
    exp_t e;
    bit   esi;
    cycles++;
    if (run_cmp) begin
      if (q.size() != 0) e = q[0];
      else begin
        e.rstn = 1; e.se = 0; e.ce = 1; e.cfg = 2'b00; e.si = 0;
        e.bsy = 0; e.dn = 0; e.req = 1; // R1 idle
      end
      esi = (e.si == 2) ? arr_scan_out : e.si[0];
      checks++;
      if (arr_rst_n !== e.rstn || arr_scan_en !== e.se || arr_clk_en !== e.ce ||
          arr_cfg !== e.cfg || arr_scan_in !== esi || busy !== e.bsy || done !== e.dn) begin
        fails++;
        $display("FAIL R%0d cycle %0d: got rst_n=%b se=%b ce=%b cfg=%b si=%b busy=%b done=%b exp %b %b %b %b %b %b %b",
                 e.req, cycles, arr_rst_n, arr_scan_en, arr_clk_en, arr_cfg, arr_scan_in, busy, done,
                 e.rstn, e.se, e.ce, e.cfg, esi, e.bsy, e.dn);
      end
    end
  end

  task automatic check_vec(string tag, logic [TILES-1:0] act, logic [TILES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic pulse(bit p, bit r);
    @(negedge clk);
    start_prog = p; start_read = r;
    @(negedge clk);
    start_prog = 0; start_read = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1) begin
      @(negedge clk);
      n++;
      if (n > 2000) begin
        fails++;
        $display("FAIL R7 watchdog: done not seen, actual 0 expected 1");
        finish_run();
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; start_prog = 0; start_read = 0; with_reset = 0; with_state = 0;
    diag_plane = 64'hA5C3_0F1E_9B2D_7764; horz_plane = 64'h1357_9BDF_0246_8ACE;
    vert_plane = 64'hFEDC_BA98_7654_3211; init_plane = 64'h8000_0000_0000_0001;
    t_ff = 64'hDEAD_BEEF_0BAD_F00D; t_diag = '0; t_horz = '0; t_vert = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (arr_scan_en !== 0 || arr_cfg !== 2'b00 || arr_rst_n !== 1 || busy !== 0 || done !== 0) begin
      fails++;
      $display("FAIL R1 reset: se=%b cfg=%b rst_n=%b busy=%b done=%b expected 0 00 1 0 0",
               arr_scan_en, arr_cfg, arr_rst_n, busy, done);
    end
    check_vec("R8 readback register after reset", rb_data, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run_cmp = 1;

    // program with reset and state load; starts mid-run must be ignored (R9)
    with_reset = 1; with_state = 1;
    pulse(1, 0);
    repeat (100) @(negedge clk);
    pulse(0, 1);
    repeat (50) @(negedge clk);
    pulse(1, 0);
    wait_done();
    check_vec("R4 diagonal plane in tiles", t_diag, diag_plane);
    check_vec("R3 horizontal plane in tiles", t_horz, horz_plane);
    check_vec("R3 vertical plane in tiles", t_vert, vert_plane);
    check_vec("R6 initial state in flip-flops", t_ff, init_plane);
    repeat (3) @(negedge clk);

    // readback restores the array (R8)
    pulse(0, 1);
    wait_done();
    check_vec("R8 readback data", rb_data, init_plane);
    check_vec("R8 array restored", t_ff, init_plane);
    repeat (2) @(negedge clk);

    // program without reset or state load
    with_reset = 0; with_state = 0;
    diag_plane = 64'h0123_4567_89AB_CDEF; horz_plane = 64'hFFFF_0000_FFFF_0000;
    vert_plane = 64'h5A5A_C3C3_0000_FFFF;
    pulse(1, 0);
    wait_done();
    check_vec("R4 diagonal plane second run", t_diag, diag_plane);
    check_vec("R6 vertical plane stays without state load", t_ff, vert_plane);
    check_vec("R8 readback register held during programming", rb_data, init_plane);
    repeat (2) @(negedge clk);

    pulse(0, 1);
    wait_done();
    check_vec("R8 readback second run", rb_data, vert_plane);

    // both starts together: programming wins (R9)
    with_state = 1; init_plane = 64'h0F0F_0F0F_F0F0_F0F0;
    pulse(1, 1);
    wait_done();
    check_vec("R9 programming chosen over readback", t_ff, init_plane);
    check_vec("R9 readback register untouched", rb_data, vert_plane);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule